// File: doc/BRIEF.md
# Station Name Character Display Sequencer

This block writes a station name onto a 16x2 character display. The display is driven over an 8-bit parallel data bus plus three control lines: register select, read/write and a latch strobe. After reset the block waits out the display's power-up time. It then sends a fixed list of set-up commands and goes idle. A receiver front end supplies a valid flag and a 3-bit station code. When the flag is high in idle, the block samples the code, moves the cursor to the start of the second line and writes the 16 characters that belong to that code. It then holds the text for as long as the flag stays high. When the flag drops, it clears the display and returns to idle.

The display's busy status is never read. Every transfer is followed by a fixed wait, and a clear command gets a longer wait than the others. All waits are parameters counted in clock cycles. The control machine has these states: ST_PWRUP, ST_INIT, ST_IDLE, ST_ADDR, ST_TEXT, ST_SHOW and ST_CLEAR. Its transitions are:

- ST_PWRUP goes to ST_INIT when the power-up count expires.
- ST_INIT steps through four commands and goes to ST_IDLE after the last one.
- ST_IDLE goes to ST_ADDR when the flag is high; this is where the code is captured.
- ST_ADDR goes to ST_TEXT after the address command.
- ST_TEXT goes to ST_SHOW after the sixteenth character.
- ST_SHOW goes to ST_CLEAR when the flag is low.
- ST_CLEAR goes to ST_IDLE after the clear command.

A separate bus-write engine generates each strobe pulse and the wait after it.

Top module: `stn_lcd_seq`

## Requirements
- R1: While reset is held, and for at least PWRUP_CYC cycles after it is released, the strobe lcd_en_o stays low.
- R2: lcd_rw_o is 0 at all times.
- R3: Each transfer drives lcd_data_o and lcd_rs_o at least one cycle before lcd_en_o rises. They stay unchanged while lcd_en_o is high. lcd_en_o stays high for exactly EHI_CYC cycles, and the display takes the byte on the falling edge.
- R4: After the power-up wait, four commands are sent with lcd_rs_o = 0, in the order 0x01, 0x38, 0x0C, 0x06.
- R5: After each strobe falls, lcd_en_o stays low for at least SHORT_CYC cycles. After the clear command (0x01 with lcd_rs_o = 0), it stays low for at least LONG_CYC cycles.
- R6: When valid_i is high in idle, the block sends command 0xC0 (lcd_rs_o = 0) and then 16 data bytes (lcd_rs_o = 1). Byte i (i = 0..15) for station code c is 0x41 + ((3*c + i) mod 26).
- R7: The station code is sampled once, when the message starts. Changes to code_i during the message have no effect on the bytes written.
- R8: While valid_i stays high after a message, no further transfers occur.
- R9: When valid_i is low after a message, exactly one clear command 0x01 (lcd_rs_o = 0) is sent, and the block then stays quiet until valid_i is high again.
- R10: If valid_i goes high during the set-up list or during a clear, that sequence completes first. The message is then written for the code present when the block reaches idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| valid_i | input | 1 | Station code valid flag |
| code_i | input | 3 | Station code |
| lcd_data_o | output | 8 | Display data bus |
| lcd_rs_o | output | 1 | Register select: 0 command, 1 character |
| lcd_rw_o | output | 1 | Read/write select, always write (0) |
| lcd_en_o | output | 1 | Latch strobe, byte taken on falling edge |

## Verification
The assertions check four properties on every cycle:
- the write-only control line;
- that the bus is stable ahead of and during each strobe;
- that there is no strobe inside the power-up window;
- the minimum low time after each strobe, using the long wait after a clear.

The order and content of the bytes can only be shown by the bench's scenarios. These cover the set-up list, the character table for every station code, the single capture of the code, the silence while the flag is held, and the clear and restart when the flag drops and rises again mid-sequence.

// File: rtl/stn_lcd_pkg.sv
package stn_lcd_pkg;

    localparam logic [7:0] CMD_CLEAR = 8'h01;
    localparam logic [7:0] CMD_LINE2 = 8'hC0;
    localparam int unsigned INIT_LEN = 4;

    typedef enum logic [2:0] {
        ST_PWRUP,
        ST_INIT,
        ST_IDLE,
        ST_ADDR,
        ST_TEXT,
        ST_SHOW,
        ST_CLEAR
    } seq_st_t;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_SETUP,
        PH_HIGH,
        PH_WAIT
    } phy_st_t;

    // Set-up list: clear, 8-bit two-line mode, display on, entry increment
    function automatic logic [7:0] init_cmd(input logic [1:0] step);
        logic [7:0] r;
        unique case (step)
            2'd0: r = CMD_CLEAR;
            2'd1: r = 8'h38;
            2'd2: r = 8'h0C;
            default: r = 8'h06;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/stn_msg_rom.sv
module stn_msg_rom #(
    parameter int unsigned CODE_W = 3,
    parameter int unsigned IDX_W  = 4
) (
    input  logic [CODE_W-1:0] code_i,
    input  logic [IDX_W-1:0]  idx_i,
    output logic [7:0]        char_o
);
    int unsigned sum;

    always_comb begin
        sum    = 3 * 32'(code_i) + 32'(idx_i);
        char_o = 8'h41 + 8'(sum % 26);
    end
endmodule

// File: rtl/lcd_wr_phy.sv
module lcd_wr_phy
    import stn_lcd_pkg::*;
#(
    parameter int unsigned SHORT_CYC = 4000,
    parameter int unsigned LONG_CYC  = 164000,
    parameter int unsigned EHI_CYC   = 25
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic [7:0] byte_i,
    input  logic       rs_i,
    output logic       ready_o,
    output logic       done_o,
    output logic [7:0] lcd_data_o,
    output logic       lcd_rs_o,
    output logic       lcd_en_o
);
    localparam int unsigned MAX_A = (LONG_CYC > SHORT_CYC) ? LONG_CYC : SHORT_CYC;
    localparam int unsigned MAX_C = (MAX_A > EHI_CYC) ? MAX_A : EHI_CYC;
    localparam int unsigned CW    = $clog2(MAX_C + 1);

    phy_st_t       st_q;
    logic [CW-1:0] cnt_q;
    logic [7:0]    data_q;
    logic          rs_q;
    logic          long_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= PH_IDLE;
            cnt_q  <= '0;
            data_q <= '0;
            rs_q   <= 1'b0;
            long_q <= 1'b0;
        end else begin
            unique case (st_q)
                PH_IDLE: begin
                    if (start_i) begin
                        data_q <= byte_i;
                        rs_q   <= rs_i;
                        long_q <= !rs_i && (byte_i == CMD_CLEAR);
                        st_q   <= PH_SETUP;
                    end
                end
                PH_SETUP: begin
                    cnt_q <= CW'(EHI_CYC - 1);
                    st_q  <= PH_HIGH;
                end
                PH_HIGH: begin
                    if (cnt_q == '0) begin
                        cnt_q <= long_q ? CW'(LONG_CYC - 1) : CW'(SHORT_CYC - 1);
                        st_q  <= PH_WAIT;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                PH_WAIT: begin
                    if (cnt_q == '0) st_q <= PH_IDLE;
                    else             cnt_q <= cnt_q - 1'b1;
                end
                default: st_q <= PH_IDLE;
            endcase
        end
    end

    always_comb begin
        ready_o    = (st_q == PH_IDLE);
        done_o     = (st_q == PH_WAIT) && (cnt_q == '0);
        lcd_en_o   = (st_q == PH_HIGH);
        lcd_data_o = data_q;
        lcd_rs_o   = rs_q;
    end
endmodule

// File: rtl/stn_lcd_seq.sv
module stn_lcd_seq
    import stn_lcd_pkg::*;
#(
    parameter int unsigned PWRUP_CYC = 1500000,
    parameter int unsigned SHORT_CYC = 4000,
    parameter int unsigned LONG_CYC  = 164000,
    parameter int unsigned EHI_CYC   = 25,
    parameter int unsigned CODE_W    = 3,
    parameter int unsigned MSG_LEN   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_i,
    input  logic [CODE_W-1:0] code_i,
    output logic [7:0]        lcd_data_o,
    output logic              lcd_rs_o,
    output logic              lcd_rw_o,
    output logic              lcd_en_o
);
    localparam int unsigned IDX_W = $clog2(MSG_LEN);
    localparam int unsigned PW    = $clog2(PWRUP_CYC + 1);

    seq_st_t           st_q, st_d;
    logic [IDX_W-1:0]  idx_q;
    logic [CODE_W-1:0] code_q;
    logic [PW-1:0]     pwr_q;
    logic              sent_q;
    logic              phy_ready, phy_done;
    logic              start, send, wr_rs;
    logic [7:0]        wr_byte, msg_char;
    logic              init_last, text_last;

    assign init_last = (idx_q == IDX_W'(INIT_LEN - 1));
    assign text_last = (idx_q == IDX_W'(MSG_LEN - 1));

    stn_msg_rom #(.CODE_W(CODE_W), .IDX_W(IDX_W)) rom_i (
        .code_i (code_q),
        .idx_i  (idx_q),
        .char_o (msg_char)
    );

    lcd_wr_phy #(.SHORT_CYC(SHORT_CYC), .LONG_CYC(LONG_CYC), .EHI_CYC(EHI_CYC)) phy_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start),
        .byte_i     (wr_byte),
        .rs_i       (wr_rs),
        .ready_o    (phy_ready),
        .done_o     (phy_done),
        .lcd_data_o (lcd_data_o),
        .lcd_rs_o   (lcd_rs_o),
        .lcd_en_o   (lcd_en_o)
    );

    // State register and sequencing counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_PWRUP;
            idx_q  <= '0;
            code_q <= '0;
            sent_q <= 1'b0;
            pwr_q  <= PW'(PWRUP_CYC - 1);
        end else begin
            st_q <= st_d;
            if (start)         sent_q <= 1'b1;
            else if (phy_done) sent_q <= 1'b0;
            if (st_q == ST_PWRUP && pwr_q != '0) pwr_q <= pwr_q - 1'b1;
            if (st_q == ST_IDLE && valid_i) code_q <= code_i;
            if (phy_done && st_q == ST_INIT) idx_q <= init_last ? '0 : idx_q + 1'b1;
            if (phy_done && st_q == ST_TEXT) idx_q <= text_last ? '0 : idx_q + 1'b1;
        end
    end

    // Next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_PWRUP: if (pwr_q == '0)                st_d = ST_INIT;
            ST_INIT:  if (phy_done && init_last)      st_d = ST_IDLE;
            ST_IDLE:  if (valid_i)                    st_d = ST_ADDR;
            ST_ADDR:  if (phy_done)                   st_d = ST_TEXT;
            ST_TEXT:  if (phy_done && text_last)      st_d = ST_SHOW;
            ST_SHOW:  if (!valid_i)                   st_d = ST_CLEAR;
            ST_CLEAR: if (phy_done)                   st_d = ST_IDLE;
            default:                                  st_d = ST_PWRUP;
        endcase
    end

    // Outputs toward the bus-write engine
    always_comb begin
        send    = 1'b0;
        wr_byte = 8'h00;
        wr_rs   = 1'b0;
        unique case (st_q)
            ST_INIT:  begin send = 1'b1; wr_byte = init_cmd(idx_q[1:0]); end
            ST_ADDR:  begin send = 1'b1; wr_byte = CMD_LINE2; end
            ST_TEXT:  begin send = 1'b1; wr_byte = msg_char; wr_rs = 1'b1; end
            ST_CLEAR: begin send = 1'b1; wr_byte = CMD_CLEAR; end
            default:  ;
        endcase
        start    = send && phy_ready && !sent_q;
        lcd_rw_o = 1'b0;
    end
endmodule

// File: rtl/stn_lcd_chk.sv
module stn_lcd_chk #(
    parameter int unsigned PWRUP_CYC = 1500000,
    parameter int unsigned SHORT_CYC = 4000,
    parameter int unsigned LONG_CYC  = 164000
) (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] lcd_data_o,
    input logic       lcd_rs_o,
    input logic       lcd_rw_o,
    input logic       lcd_en_o
);
    logic [31:0] since_q, gap_q, need_q;
    logic        en_prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_q   <= '0;
            gap_q     <= '0;
            need_q    <= '0;
            en_prev_q <= 1'b0;
        end else begin
            en_prev_q <= lcd_en_o;
            if (since_q != 32'hFFFF_FFFF) since_q <= since_q + 1;
            if (en_prev_q && !lcd_en_o) begin
                gap_q  <= 32'd1;
                need_q <= (!lcd_rs_o && lcd_data_o == 8'h01) ? LONG_CYC : SHORT_CYC;
            end else if (!lcd_en_o && gap_q != 32'hFFFF_FFFF) begin
                gap_q <= gap_q + 1;
            end
        end
    end

    AST_PWRUP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (since_q < PWRUP_CYC) |-> !lcd_en_o);  // R1
    AST_WRITE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        !lcd_rw_o);  // R2
    AST_BUS_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
        (lcd_en_o && !en_prev_q) |-> ($stable(lcd_data_o) && $stable(lcd_rs_o)));  // R3
    AST_BUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        lcd_en_o |=> (!lcd_en_o || ($stable(lcd_data_o) && $stable(lcd_rs_o))));  // R3
    AST_LOW_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (lcd_en_o && !en_prev_q) |-> (gap_q >= need_q));  // R5
endmodule

bind stn_lcd_seq stn_lcd_chk #(
    .PWRUP_CYC (PWRUP_CYC),
    .SHORT_CYC (SHORT_CYC),
    .LONG_CYC  (LONG_CYC)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .lcd_data_o (lcd_data_o),
    .lcd_rs_o   (lcd_rs_o),
    .lcd_rw_o   (lcd_rw_o),
    .lcd_en_o   (lcd_en_o)
);

// File: tb/stn_lcd_seq_tb_top.sv
module stn_lcd_seq_tb_top;
    localparam int PW = 50;
    localparam int SH = 5;
    localparam int LG = 20;
    localparam int EH = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       valid = 1'b0;
    logic [2:0] code = 3'd0;
    logic [7:0] data;
    logic       rs, rw, en;

    always #5 clk = ~clk;

    stn_lcd_seq #(.PWRUP_CYC(PW), .SHORT_CYC(SH), .LONG_CYC(LG), .EHI_CYC(EH)) dut_i (
        .clk(clk), .rst_n(rst_n), .valid_i(valid), .code_i(code),
        .lcd_data_o(data), .lcd_rs_o(rs), .lcd_rw_o(rw), .lcd_en_o(en)
    );

    int checks = 0;
    int errors = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Bus monitor: logs every byte taken on a strobe falling edge
    logic       en_prev = 1'b0;
    bit         seen = 1'b0;
    int         since_rst = 0, hi_cnt = 0, low_cnt = 0, need = 0;
    logic [8:0] rise_val = '0;
    logic [8:0] log_q [512];
    int         log_n = 0;
    int         cyc = 0;

    always @(negedge clk) begin
        if (!rst_n) begin
            since_rst = 0;
            en_prev   = 1'b0;
        end else begin
            since_rst++;
            if (en && !en_prev) begin
                if (!seen) chk(since_rst >= PW, "R1 first strobe after power-up wait", since_rst, PW);
                else       chk(low_cnt >= need, "R5 strobe low gap", low_cnt, need);
                chk(rw == 1'b0, "R2 read/write line low", int'(rw), 0);
                seen     = 1'b1;
                hi_cnt   = 1;
                rise_val = {rs, data};
            end else if (en) begin
                hi_cnt++;
            end else if (en_prev) begin
                chk(hi_cnt == EH, "R3 strobe high width", hi_cnt, EH);
                chk({rs, data} == rise_val, "R3 bus stable while strobe high", int'({rs, data}), int'(rise_val));
                if (log_n < 512) log_q[log_n] = {rs, data};
                log_n++;
                need    = (!rs && data == 8'h01) ? LG : SH;
                low_cnt = 1;
            end else begin
                low_cnt++;
            end
            en_prev = en;
        end
    end

    always @(negedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 150000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic wait_log(input int n);
        while (log_n < n) @(negedge clk);
    endtask

    task automatic expect_msg(input int base, input int c, input string tag);
        chk(log_q[base] == 9'h0C0, {"R6 line-2 address ", tag}, int'(log_q[base]), 'h0C0);
        for (int i = 0; i < 16; i++) begin
            int e = 256 + 65 + ((3 * c + i) % 26);
            chk(int'(log_q[base + 1 + i]) == e, {"R6 message byte ", tag}, int'(log_q[base + 1 + i]), e);
        end
    endtask

    task automatic expect_clear(input int idx, input string tag);
        chk(log_q[idx] == 9'h001, {"R9 clear command ", tag}, int'(log_q[idx]), 'h001);
    endtask

    initial begin
        int base;
        int n;
        int init_exp [4] = '{'h01, 'h38, 'h0C, 'h06};
        valid = 1'b1;
        code  = 3'd5;
        repeat (5) @(negedge clk);
        chk(en == 1'b0, "R1 strobe low in reset", int'(en), 0);
        chk(rw == 1'b0, "R2 read/write low in reset", int'(rw), 0);
        rst_n = 1'b1;

        // R10: flag already high during set-up list; R7: code changes mid-message
        wait_log(6);
        code = 3'd2;
        wait_log(21);
        for (int i = 0; i < 4; i++)
            chk(int'(log_q[i]) == init_exp[i], "R4 set-up command order", int'(log_q[i]), init_exp[i]);
        expect_msg(4, 5, "R7 R10 code held from message start");

        // R8: no transfers while flag held high
        n = log_n;
        repeat (100) @(negedge clk);
        chk(log_n == n, "R8 silent while flag high", log_n, n);

        // R9 then R10: flag rises again during the clear wait
        valid = 1'b0;
        wait_log(22);
        expect_clear(21, "after first message");
        code  = 3'd7;
        valid = 1'b1;
        wait_log(39);
        expect_msg(22, 7, "R10 rise during clear");

        // Sweep all station codes through the idle path
        for (int c = 0; c < 8; c++) begin
            valid = 1'b0;
            base = log_n;
            wait_log(base + 1);
            expect_clear(base, "sweep");
            repeat (40) @(negedge clk);
            chk(log_n == base + 1, "R9 single clear then idle", log_n, base + 1);
            code  = 3'(c);
            valid = 1'b1;
            base = log_n;
            wait_log(base + 17);
            expect_msg(base, c, "sweep");
            repeat (10) @(negedge clk);
        end

        valid = 1'b0;
        base = log_n;
        wait_log(base + 1);
        expect_clear(base, "final");
        repeat (80) @(negedge clk);
        chk(log_n == base + 1, "R9 idle after final clear", log_n, base + 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule